// File: doc/BRIEF.md
# Four-Level Prioritized Interrupt Controller

This block arbitrates six interrupt sources for a small 8-bit CPU core. The six sources are:

- two external request pins (active low), each in level or edge mode;
- two timer overflow flags;
- a serial port flag pair (receive and transmit) that shares one request;
- a second timer's flag pair (overflow and external capture) that shares one request.

Software programs the block through a simple register write port. It sets per-source enables, a global enable, two priority-bit registers that together give each source one of four levels, and the edge/level mode of the external pins. It can also set or clear any request flag directly.

The CPU drives a machine-cycle strobe and tells the block about the instruction in progress. It flags the last cycle of an instruction, a return from a handler, and a write to the enable or priority registers. Request flags are captured on each strobe and judged on the next one. When a request wins and nothing blocks it, the block raises a one-clock vector request carrying the source index and the level. In the same clock it clears the flag when the source type calls for that, and reports the clear. A per-level in-progress record tracks nesting: only a request above the highest active level can preempt a running handler. A request that loses while blocked is not remembered.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Source index on `vec_idx_o`: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 second timer. Among requests of one level, the lowest index wins.
- R2: The level of source s is {prio-high bit s, prio-low bit s}. The prio-low register is select 1 and prio-high is select 2, bit s for source s. Across levels, the highest level wins.
- R3: Select 0 holds the per-source enables (bit s for source s) and the global enable (bit 7). A disabled source, or any source while bit 7 is 0, is never vectored.
- R4: A request is vectored only if its level is above the highest in-progress level. A level-3 handler is never preempted, and equal levels never preempt.
- R5: Flags are captured on a clock with `mcyc_i` high and judged on the next such clock. `vec_valid_o` pulses for one clock after that second strobe edge.
- R6: No vector is issued from a strobe where `last_cyc_i` is low, `reti_i` is high or `cfg_wr_i` is high.
- R7: A request whose flag is cleared while it is blocked is never vectored afterwards.
- R8: With mode register (select 3) bit e set, external e is in edge mode. A falling pin edge sets its flag, and vectoring clears it with `vec_clr_o` high.
- R9: In level mode, the external flag follows the inverted pin every clock and is not cleared by vectoring (`vec_clr_o` low).
- R10: Vectoring clears the timer 0/1 flags and reports `vec_clr_o` high. Serial and second-timer flags are never cleared by hardware (`vec_clr_o` low).
- R11: The flag register is select 4, read back on `flags_o`. Its bits are: 0 ext0, 1 tmr0, 2 ext1, 3 tmr1, 4 rx, 5 tx, 6 t2 overflow, 7 t2 external. A write sets or clears each flag directly.
- R12: A strobe with `reti_i` high clears the highest set in-progress level bit.
- R13: After reset, all flags, enables, priorities and in-progress bits are zero, both externals are in level mode, and `vec_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_n_i | input | 2 | External request pins, active low |
| tmr_ovf_i | input | 2 | Timer 0/1 overflow set pulses |
| ser_rx_i | input | 1 | Serial receive flag set pulse |
| ser_tx_i | input | 1 | Serial transmit flag set pulse |
| t2_ovf_i | input | 1 | Second timer overflow set pulse |
| t2_ext_i | input | 1 | Second timer external flag set pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select |
| wr_data_i | input | 8 | Register write data |
| mcyc_i | input | 1 | Machine-cycle strobe |
| last_cyc_i | input | 1 | Current cycle ends the instruction |
| reti_i | input | 1 | Instruction is a return from handler |
| cfg_wr_i | input | 1 | Instruction writes enable/priority |
| vec_valid_o | output | 1 | Vector request pulse |
| vec_idx_o | output | 3 | Vectored source index |
| vec_lvl_o | output | 2 | Vectored level |
| vec_clr_o | output | 1 | Hardware cleared the source flag |
| flags_o | output | 8 | Request flag readback |

## Verification
With the strobe held high, a flag written at edge A is captured at A+1 and vectored at A+2. The bench therefore samples `vec_valid_o` at the falling edge after A+2. An enable write acts on an already captured request, so that vector appears one edge after the write. An edge-mode pin fall needs one extra edge to set the flag, so its vector is due three edges after the fall. A monitor counts vector pulses one delay step after each rising edge. Blocking and "no effect" checks compare that count before and after a window, so a pulse missed between samples still fails the check.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC   = 6;
  localparam int NLVL   = 4;
  localparam int LVLW   = $clog2(NLVL);
  localparam int IDXW   = $clog2(NSRC);
  localparam int DW     = 8;
  localparam int NFLG   = 8;
  localparam int NEXT   = 2;
  localparam int EA_BIT = 7;
  localparam int NHWCLR = 4;  // sources 0..3 map 1:1 onto flag bits 0..3

  typedef enum logic [2:0] {
    SEL_EN   = 3'd0,
    SEL_PLO  = 3'd1,
    SEL_PHI  = 3'd2,
    SEL_MODE = 3'd3,
    SEL_FLAG = 3'd4
  } reg_sel_e;

  function automatic logic [LVLW-1:0] top_level(input logic [NLVL-1:0] act);
    logic [LVLW-1:0] t;
    t = '0;
    for (int l = 0; l < NLVL; l++) if (act[l]) t = LVLW'(l);
    return t;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [2:0]      wr_sel_i,
  input  logic [DW-1:0]   wr_data_i,
  output logic [NSRC-1:0] src_en_o,
  output logic            ea_o,
  output logic [NSRC-1:0] plo_o,
  output logic [NSRC-1:0] phi_o,
  output logic [NEXT-1:0] edge_mode_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_en_o    <= '0;
      ea_o        <= 1'b0;
      plo_o       <= '0;
      phi_o       <= '0;
      edge_mode_o <= '0;
    end else if (wr_en_i) begin
      case (sel)
        SEL_EN: begin
          src_en_o <= wr_data_i[NSRC-1:0];
          ea_o     <= wr_data_i[EA_BIT];
        end
        SEL_PLO:  plo_o       <= wr_data_i[NSRC-1:0];
        SEL_PHI:  phi_o       <= wr_data_i[NSRC-1:0];
        SEL_MODE: edge_mode_o <= wr_data_i[NEXT-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NEXT-1:0] ext_n_i,
  input  logic [NEXT-1:0] edge_mode_i,
  input  logic [NEXT-1:0] tmr_set_i,
  input  logic            rx_set_i,
  input  logic            tx_set_i,
  input  logic            t2_ovf_set_i,
  input  logic            t2_ext_set_i,
  input  logic            sw_we_i,
  input  logic [DW-1:0]   sw_data_i,
  input  logic [NFLG-1:0] hw_clr_i,
  output logic [NFLG-1:0] flags_o
);
  logic [NEXT-1:0] pin_q;
  logic [NFLG-1:0] hw_set, lvl_trk, lvl_val, flag_q, flag_d;

  // externals at even bits, timers at odd bits of the low nibble
  for (genvar e = 0; e < NEXT; e++) begin : g_pair
    assign hw_set[2*e]    = edge_mode_i[e] & pin_q[e] & ~ext_n_i[e];
    assign hw_set[2*e+1]  = tmr_set_i[e];
    assign lvl_trk[2*e]   = ~edge_mode_i[e];
    assign lvl_trk[2*e+1] = 1'b0;
    assign lvl_val[2*e]   = ~ext_n_i[e];
    assign lvl_val[2*e+1] = 1'b0;
  end
  assign hw_set[NFLG-1:2*NEXT]  = {t2_ext_set_i, t2_ovf_set_i, tx_set_i, rx_set_i};
  assign lvl_trk[NFLG-1:2*NEXT] = '0;
  assign lvl_val[NFLG-1:2*NEXT] = '0;

  always_comb begin
    for (int b = 0; b < NFLG; b++) begin
      flag_d[b] = flag_q[b];
      if (hw_clr_i[b]) flag_d[b] = 1'b0;
      if (hw_set[b])   flag_d[b] = 1'b1;
      if (lvl_trk[b])  flag_d[b] = lvl_val[b];
      if (sw_we_i)     flag_d[b] = sw_data_i[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= '1;
      flag_q <= '0;
    end else begin
      pin_q  <= ext_n_i;
      flag_q <= flag_d;
    end
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] plo_i,
  input  logic [NSRC-1:0] phi_i,
  input  logic            poll_i,
  input  logic            act_any_i,
  input  logic [LVLW-1:0] act_top_i,
  output logic            grant_o,
  output logic [IDXW-1:0] idx_o,
  output logic [LVLW-1:0] lvl_o
);
  logic found;

  always_comb begin
    found = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    for (int l = NLVL - 1; l >= 0; l--) begin
      for (int s = 0; s < NSRC; s++) begin
        if (!found && req_i[s] && ({phi_i[s], plo_i[s]} == LVLW'(l))) begin
          found = 1'b1;
          idx_o = IDXW'(s);
          lvl_o = LVLW'(l);
        end
      end
    end
  end

  assign grant_o = poll_i && found && (!act_any_i || (lvl_o > act_top_i));
endmodule

// File: rtl/irq_inprog.sv
module irq_inprog
  import irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic [LVLW-1:0] set_lvl_i,
  input  logic            ret_i,
  output logic [NLVL-1:0] act_o,
  output logic            any_o,
  output logic [LVLW-1:0] top_o
);
  logic [NLVL-1:0] act_q, act_d;
  logic            hit;

  always_comb begin
    act_d = act_q;
    hit   = 1'b0;
    if (ret_i) begin
      for (int l = NLVL - 1; l >= 0; l--) begin
        if (!hit && act_q[l]) begin
          act_d[l] = 1'b0;
          hit      = 1'b1;
        end
      end
    end
    if (set_i) act_d[set_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act_d;
  end

  assign act_o = act_q;
  assign any_o = |act_q;
  assign top_o = top_level(act_q);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  ext_n_i,
  input  logic [1:0]  tmr_ovf_i,
  input  logic        ser_rx_i,
  input  logic        ser_tx_i,
  input  logic        t2_ovf_i,
  input  logic        t2_ext_i,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_sel_i,
  input  logic [7:0]  wr_data_i,
  input  logic        mcyc_i,
  input  logic        last_cyc_i,
  input  logic        reti_i,
  input  logic        cfg_wr_i,
  output logic        vec_valid_o,
  output logic [2:0]  vec_idx_o,
  output logic [1:0]  vec_lvl_o,
  output logic        vec_clr_o,
  output logic [7:0]  flags_o
);
  logic [NSRC-1:0] src_en, plo, phi, src_raw, samp_q, req;
  logic [NEXT-1:0] edge_mode;
  logic            ea_q;
  logic [NFLG-1:0] flags, hw_clr;
  logic            grant, poll, act_any, clr_now, is_ext;
  logic [IDXW-1:0] win_idx;
  logic [LVLW-1:0] win_lvl, act_top;
  logic [NLVL-1:0] inprog;

  irq_cfg_regs u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .src_en_o(src_en), .ea_o(ea_q), .plo_o(plo), .phi_o(phi), .edge_mode_o(edge_mode)
  );

  irq_flag_bank u_flags (
    .clk_i, .rst_ni,
    .ext_n_i(ext_n_i), .edge_mode_i(edge_mode), .tmr_set_i(tmr_ovf_i),
    .rx_set_i(ser_rx_i), .tx_set_i(ser_tx_i), .t2_ovf_set_i(t2_ovf_i), .t2_ext_set_i(t2_ext_i),
    .sw_we_i(wr_en_i && (wr_sel_i == SEL_FLAG)), .sw_data_i(wr_data_i),
    .hw_clr_i(hw_clr), .flags_o(flags)
  );

  assign src_raw = {|flags[7:6], |flags[5:4], flags[3:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     samp_q <= '0;
    else if (mcyc_i) samp_q <= src_raw;
  end

  assign req  = samp_q & src_en & {NSRC{ea_q}};
  assign poll = mcyc_i && last_cyc_i && !reti_i && !cfg_wr_i;

  irq_arbiter u_arb (
    .req_i(req), .plo_i(plo), .phi_i(phi), .poll_i(poll),
    .act_any_i(act_any), .act_top_i(act_top),
    .grant_o(grant), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  irq_inprog u_inprog (
    .clk_i, .rst_ni, .set_i(grant), .set_lvl_i(win_lvl),
    .ret_i(mcyc_i && reti_i),
    .act_o(inprog), .any_o(act_any), .top_o(act_top)
  );

  // level-mode externals are owned by the pin, not by hardware clear
  assign is_ext  = (win_idx == IDXW'(0)) || (win_idx == IDXW'(2));
  assign clr_now = grant && (win_idx < IDXW'(NHWCLR)) && !(is_ext && !edge_mode[win_idx[1]]);
  assign hw_clr  = clr_now ? (NFLG'(1) << win_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_valid_o <= 1'b0;
      vec_idx_o   <= '0;
      vec_lvl_o   <= '0;
      vec_clr_o   <= 1'b0;
    end else begin
      vec_valid_o <= grant;
      vec_clr_o   <= clr_now;
      if (grant) begin
        vec_idx_o <= win_idx;
        vec_lvl_o <= win_lvl;
      end
    end
  end

  assign flags_o = flags;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mcyc_i,
  input logic            last_cyc_i,
  input logic            reti_i,
  input logic            cfg_wr_i,
  input logic            vec_valid_o,
  input logic [2:0]      vec_idx_o,
  input logic [1:0]      vec_lvl_o,
  input logic            vec_clr_o,
  input logic            ea_i,
  input logic [NLVL-1:0] inprog_i
);
  assert_vec_on_poll_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(mcyc_i && last_cyc_i && !reti_i && !cfg_wr_i));

  assert_vec_needs_ea_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(ea_i));

  assert_no_hw_clr_shared_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && (vec_idx_o >= 3'd4)) |-> !vec_clr_o);

  assert_tmr_hw_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && (vec_idx_o == 3'd1 || vec_idx_o == 3'd3)) |-> vec_clr_o);

  assert_preempt_above_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && $past(inprog_i != '0)) |-> (vec_lvl_o > top_level($past(inprog_i))));

  assert_reti_pops_one_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcyc_i && reti_i && (inprog_i != '0)) |=> ($countones(inprog_i) == $countones($past(inprog_i)) - 1));

  assert_clr_only_with_vec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_clr_o |-> vec_valid_o);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mcyc_i(mcyc_i), .last_cyc_i(last_cyc_i),
  .reti_i(reti_i), .cfg_wr_i(cfg_wr_i), .vec_valid_o(vec_valid_o),
  .vec_idx_o(vec_idx_o), .vec_lvl_o(vec_lvl_o), .vec_clr_o(vec_clr_o),
  .ea_i(ea_q), .inprog_i(inprog)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ext_n;
  logic [1:0] tmr_ovf;
  logic       ser_rx, ser_tx, t2_ovf, t2_ext;
  logic       wr_en;
  logic [2:0] wr_sel;
  logic [7:0] wr_data;
  logic       mcyc, last_cyc, reti, cfg_wr;
  logic       vec_valid_o, vec_clr_o;
  logic [2:0] vec_idx_o;
  logic [1:0] vec_lvl_o;
  logic [7:0] flags_o;

  int n_run = 0, n_fail = 0, vcnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .ext_n_i(ext_n), .tmr_ovf_i(tmr_ovf),
    .ser_rx_i(ser_rx), .ser_tx_i(ser_tx), .t2_ovf_i(t2_ovf), .t2_ext_i(t2_ext),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .mcyc_i(mcyc), .last_cyc_i(last_cyc), .reti_i(reti), .cfg_wr_i(cfg_wr),
    .vec_valid_o(vec_valid_o), .vec_idx_o(vec_idx_o), .vec_lvl_o(vec_lvl_o),
    .vec_clr_o(vec_clr_o), .flags_o(flags_o)
  );

  always @(posedge clk) begin
    #1;
    if (rst_n && vec_valid_o) vcnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] sel, input logic [7:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1;
    step(1);
    reti = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ext_n = 2'b11; tmr_ovf = '0; ser_rx = 0; ser_tx = 0;
    t2_ovf = 0; t2_ext = 0; wr_en = 0; wr_sel = '0; wr_data = '0;
    mcyc = 1; last_cyc = 1; reti = 0; cfg_wr = 0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic setup();
    do_reset();
    wreg(3'd0, 8'hBF);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R13 flags", flags_o, 0);
    chk("R13 vec_valid", vec_valid_o, 0);
    ext_n[0] = 1'b0;
    step(1);
    chk("R13 level mode after reset", flags_o[0], 1);
    ext_n[0] = 1'b1;
  endtask

  task automatic t_order();
    setup();
    wreg(3'd4, 8'h5A);
    step(1);
    chk("R5 not yet", vec_valid_o, 0);
    step(1);
    chk("R1 valid", vec_valid_o, 1);
    chk("R1 idx tmr0 first", vec_idx_o, 1);
    chk("R10 tmr clr", vec_clr_o, 1);
    chk("R10 tmr0 flag cleared", flags_o, 8'h58);
    setup();
    wreg(3'd4, 8'h90);
    step(2);
    chk("R1 serial idx", vec_idx_o, 4);
    chk("R10 serial no clr", vec_clr_o, 0);
    chk("R10 serial flags kept", flags_o, 8'h90);
  endtask

  task automatic t_levels();
    setup();
    wreg(3'd1, 8'h08);
    wreg(3'd2, 8'h20);
    wreg(3'd4, 8'h4A);
    step(2);
    chk("R2 valid", vec_valid_o, 1);
    chk("R2 idx t2", vec_idx_o, 5);
    chk("R2 lvl", vec_lvl_o, 2);
  endtask

  task automatic t_enable();
    int c0;
    do_reset();
    wreg(3'd0, 8'h3F);
    c0 = vcnt;
    wreg(3'd4, 8'h02);
    step(4);
    chk("R3 global off", vcnt - c0, 0);
    wreg(3'd0, 8'hBD);
    step(4);
    chk("R3 source off", vcnt - c0, 0);
    wreg(3'd0, 8'hBF);
    step(1);
    chk("R3 enabled vector", vec_valid_o, 1);
    chk("R3 idx", vec_idx_o, 1);
  endtask

  task automatic t_preempt();
    int c0;
    setup();
    wreg(3'd1, 8'h08);
    wreg(3'd4, 8'h02);
    step(2);
    chk("R4 first lvl0", vec_lvl_o, 0);
    c0 = vcnt;
    wreg(3'd4, 8'h10);
    step(4);
    chk("R4 equal no preempt", vcnt - c0, 0);
    wreg(3'd4, 8'h18);
    step(2);
    chk("R4 higher preempts", vec_valid_o, 1);
    chk("R4 idx", vec_idx_o, 3);
    chk("R4 lvl", vec_lvl_o, 1);
    setup();
    wreg(3'd1, 8'h0A);
    wreg(3'd2, 8'h0A);
    wreg(3'd4, 8'h02);
    step(2);
    chk("R4 lvl3 vec", vec_lvl_o, 3);
    c0 = vcnt;
    wreg(3'd4, 8'h08);
    step(5);
    chk("R4 lvl3 not preempted", vcnt - c0, 0);
  endtask

  task automatic t_block();
    int c0;
    setup();
    c0 = vcnt;
    last_cyc = 1'b0;
    wreg(3'd4, 8'h02);
    step(4);
    chk("R6 last_cyc block", vcnt - c0, 0);
    last_cyc = 1'b1; reti = 1'b1;
    step(3);
    chk("R6 reti block", vcnt - c0, 0);
    reti = 1'b0; cfg_wr = 1'b1;
    step(3);
    chk("R6 cfg_wr block", vcnt - c0, 0);
    wreg(3'd4, 8'h00);
    step(2);
    cfg_wr = 1'b0;
    step(4);
    chk("R7 not remembered", vcnt - c0, 0);
    wreg(3'd4, 8'h02);
    step(2);
    chk("R7 control vector", vec_valid_o, 1);
  endtask

  task automatic t_ext();
    setup();
    wreg(3'd3, 8'h01);
    ext_n[0] = 1'b0;
    step(3);
    chk("R8 edge vector", vec_valid_o, 1);
    chk("R8 idx", vec_idx_o, 0);
    chk("R8 clr", vec_clr_o, 1);
    chk("R8 flag cleared", flags_o[0], 0);
    step(3);
    chk("R8 held low no reset", flags_o[0], 0);
    setup();
    ext_n[1] = 1'b0;
    step(3);
    chk("R9 level vector", vec_valid_o, 1);
    chk("R9 idx", vec_idx_o, 2);
    chk("R9 no clr", vec_clr_o, 0);
    chk("R9 flag held", flags_o[2], 1);
    ext_n[1] = 1'b1;
    step(1);
    chk("R9 follows pin", flags_o[2], 0);
  endtask

  task automatic t_timing();
    int c0;
    setup();
    mcyc = 1'b0;
    c0 = vcnt;
    wreg(3'd4, 8'h02);
    step(3);
    chk("R5 no strobe", vcnt - c0, 0);
    mcyc = 1'b1; step(1); mcyc = 1'b0;
    chk("R5 capture strobe", vec_valid_o, 0);
    step(2);
    chk("R5 idle", vcnt - c0, 0);
    mcyc = 1'b1; step(1); mcyc = 1'b0;
    chk("R5 poll strobe", vec_valid_o, 1);
    chk("R5 idx", vec_idx_o, 1);
  endtask

  task automatic t_swflags();
    do_reset();
    wreg(3'd4, 8'hF0);
    chk("R11 set", flags_o, 8'hF0);
    tmr_ovf = 2'b10; ser_tx = 1'b0;
    step(1);
    tmr_ovf = 2'b00;
    chk("R11 hw set tmr1", flags_o, 8'hF8);
    wreg(3'd4, 8'h00);
    chk("R11 clear", flags_o, 0);
  endtask

  task automatic t_reti();
    setup();
    wreg(3'd1, 8'h08);
    wreg(3'd4, 8'h02);
    step(2);
    chk("R12 lvl0 in", vec_lvl_o, 0);
    wreg(3'd4, 8'h08);
    step(2);
    chk("R12 lvl1 in", vec_lvl_o, 1);
    wreg(3'd4, 8'h10);
    step(3);
    do_reti();
    wreg(3'd4, 8'h18);
    step(2);
    chk("R12 lvl1 freed", vec_valid_o, 1);
    chk("R12 idx", vec_idx_o, 3);
    step(2);
    do_reti();
    do_reti();
    step(1);
    chk("R12 all freed serial", vec_valid_o, 1);
    chk("R12 serial idx", vec_idx_o, 4);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_order();
    t_levels();
    t_enable();
    t_preempt();
    t_block();
    t_ext();
    t_timing();
    t_swflags();
    t_reti();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule